// File: doc/BRIEF.md
# SDRAM Command Mode Engine

This block turns one software command word into SDRAM bus commands for two chip-select banks. The word holds an operating mode, a target mask that names one or both banks, a repeat count for auto-refresh and a value for the device mode register. While a command is running the engine raises a busy flag. Software polls this flag before it writes the next word, and a word written while the flag is high is dropped. The power-up order that software follows is clock enable, a wait of at least 200 µs, precharge all, eight auto-refreshes, load mode register, then normal mode.

Separate from the command path, a refresh interval counter starts when a bank enters normal mode. Each time it expires, the engine issues one auto-refresh to every bank that is in normal operation. The command spacings of the memory (precharge period, row cycle, mode-register-set delay) are module parameters.

The sequencer has three states. IDLE waits and keeps the bus deselected. ISSUE drives one bus command for one clock. GAP counts down the spacing that the command needs. The transitions are IDLE→ISSUE when a word is accepted or a periodic refresh is taken, ISSUE→GAP for commands that have a spacing, ISSUE→IDLE for the others, GAP→ISSUE for the next repeat of an auto-refresh, and GAP→IDLE when the spacing has elapsed.

Top module: `sdram_cmd_engine`

## Requirements
- R1: After reset, busy is 0, both CKE lines are 0, both chip selects are high and RAS/CAS/WE are high.
- R2: Command word fields are mode in bits [2:0], the bank-2 select in bit 3, the bank-1 select in bit 4, the repeat count in bits [8:5] and the mode-register value in bits [21:9]. When busy is low, a write with mode 0 to 6 sets busy in the next cycle. A write with mode 7 is dropped and busy stays 0.
- R3: A word written while busy is high is dropped. It does not change CKE and issues no bus command.
- R4: Bank 1 is driven on chip select 0 and CKE 0. Bank 2 is driven on chip select 1 and CKE 1. A command reaches only the banks it selects.
- R5: Mode 1 (clock enable) raises CKE of the selected banks in the cycle after the write. It issues no bus command and busy lasts one cycle.
- R6: Mode 2 (precharge all) issues RAS=0, CAS=1, WE=0 with address bit 10 high in the cycle after the write. Busy then lasts T_RP cycles.
- R7: Mode 3 (auto-refresh) issues repeat count + 1 refresh commands (RAS=0, CAS=0, WE=1), spaced T_RC cycles apart. Busy clears T_RC cycles after the last one.
- R8: Mode 4 (load mode register) issues RAS=CAS=WE=0, with the address equal to the word's bits [21:9] and the bank address 0. Busy lasts T_MRD cycles.
- R9: Mode 0 (normal) raises CKE of the selected banks, enables periodic refresh for them and restarts the interval counter. It issues no bus command.
- R10: The interval register takes the interval I written as I shifted left by one. After a normal-mode write, the first periodic refresh goes out I+2 cycles later and the following ones every I+1 cycles. Each goes to all banks in normal operation.
- R11: Mode 5 (self-refresh) issues a refresh command with CKE already low on the selected banks. Mode 6 (power-down) lowers CKE with no command. Both modes stop periodic refresh for those banks.
- R12: Each bus command lasts one cycle and is followed by a deselect cycle. While busy is low the bus is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Command word |
| rfi_wr | input | 1 | Refresh interval write strobe |
| rfi_word | input | 14 | Refresh interval, written as interval shifted left by one |
| busy | output | 1 | A command or periodic refresh is running |
| sd_cs_n | output | 2 | Chip selects, bit 0 bank 1, bit 1 bank 2 |
| sd_cke | output | 2 | Clock enables, bit 0 bank 1, bit 1 bank 2 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | 13 | Address lines |
| sd_ba | output | 2 | Bank address |

## Verification
A bus command appears in the first cycle after the edge that accepts the word. CKE changes on that same edge. Busy falls exactly T_RP, T_RC after the last refresh, or T_MRD cycles after the command, and one cycle after commands that have no spacing. The first periodic refresh comes I+2 cycles after the normal-mode edge, because it passes through the counter, the request register and the state register. Each scenario task counts cycles from the accepting edge and samples on the falling clock edge. This lets it check the exact cycle of every command, CKE change and busy transition, and the deselect cycles between them.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL     = 3'd0,
        MODE_CKE_ON     = 3'd1,
        MODE_PRECHARGE  = 3'd2,
        MODE_AUTOREF    = 3'd3,
        MODE_LOAD_MR    = 3'd4,
        MODE_SELF_REF   = 3'd5,
        MODE_POWER_DOWN = 3'd6,
        MODE_RESERVED   = 3'd7
    } op_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP
    } eng_state_t;

    localparam int NUM_CS     = 2;
    localparam int MODE_LSB   = 0;
    localparam int SEL_B2_BIT = 3;
    localparam int SEL_B1_BIT = 4;
    localparam int REP_LSB    = 5;
    localparam int REP_W      = 4;
    localparam int MRV_LSB    = REP_LSB + REP_W;
    localparam int A10_BIT    = 10;

endpackage

// File: rtl/sdram_bank_ctl.sv
module sdram_bank_ctl
    import sdram_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  op_mode_t          acc_mode,
    input  logic [NUM_CS-1:0] acc_tgt,
    output logic [NUM_CS-1:0] cke,
    output logic [NUM_CS-1:0] ref_en
);

    for (genvar b = 0; b < NUM_CS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cke[b]    <= 1'b0;
                ref_en[b] <= 1'b0;
            end else if (accept && acc_tgt[b]) begin
                case (acc_mode)
                    MODE_NORMAL: begin
                        cke[b]    <= 1'b1;
                        ref_en[b] <= 1'b1;
                    end
                    MODE_CKE_ON: cke[b] <= 1'b1;
                    MODE_SELF_REF, MODE_POWER_DOWN: begin
                        cke[b]    <= 1'b0;
                        ref_en[b] <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int              RT_W     = 14,
    parameter logic [RT_W-1:0] RT_RESET = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rt_wr,
    input  logic [RT_W-1:0] rt_word,
    input  logic            restart,
    input  logic            run,
    input  logic            ack,
    output logic            req
);

    localparam logic [RT_W-1:0] STEP = RT_W'(2);

    logic [RT_W-1:0] rt_reg;
    logic [RT_W-1:0] cnt;
    logic            expire;

    // The stored word is the interval shifted left by one, so the counter steps by two.
    assign expire = run && !restart && (cnt < STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_reg <= RT_RESET;
            cnt    <= RT_RESET;
            req    <= 1'b0;
        end else begin
            if (rt_wr) begin
                rt_reg <= rt_word;
            end
            if (restart) begin
                cnt <= rt_reg;
            end else if (run) begin
                cnt <= (cnt < STEP) ? rt_reg : cnt - STEP;
            end
            req <= run && ((req && !ack) || expire);
        end
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int T_RP   = 3,
    parameter int T_RC   = 7,
    parameter int T_MRD  = 2,
    localparam int CMD_W = MRV_LSB + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              ref_req,
    input  logic [NUM_CS-1:0] ref_mask,
    output logic              accept,
    output op_mode_t          acc_mode,
    output logic [NUM_CS-1:0] acc_tgt,
    output logic              ref_ack,
    output logic              busy,
    output logic [NUM_CS-1:0] cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    localparam int T_MAX1 = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int T_MAX  = (T_MAX1 > T_MRD) ? T_MAX1 : T_MRD;
    localparam int TMR_W  = (T_MAX < 2) ? 1 : $clog2(T_MAX);

    eng_state_t        state_q, state_d;
    op_mode_t          mode_q, mode_d;
    logic [NUM_CS-1:0] tgt_q, tgt_d;
    logic [REP_W-1:0]  rep_q, rep_d;
    logic [ADDR_W-1:0] mrv_q, mrv_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;

    function automatic int gap_of(op_mode_t m);
        case (m)
            MODE_PRECHARGE: return T_RP;
            MODE_AUTOREF:   return T_RC;
            MODE_LOAD_MR:   return T_MRD;
            default:        return 0;
        endcase
    endfunction

    assign acc_mode = op_mode_t'(cmd_word[MODE_LSB +: 3]);
    assign acc_tgt  = {cmd_word[SEL_B2_BIT], cmd_word[SEL_B1_BIT]};
    assign accept   = cmd_wr && (state_q == ST_IDLE) && (acc_mode != MODE_RESERVED);
    assign ref_ack  = (state_q == ST_IDLE) && !accept && ref_req && (|ref_mask);
    assign busy     = (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        tgt_d   = tgt_q;
        rep_d   = rep_q;
        mrv_d   = mrv_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    mode_d  = acc_mode;
                    tgt_d   = acc_tgt;
                    rep_d   = cmd_word[REP_LSB +: REP_W];
                    mrv_d   = cmd_word[MRV_LSB +: ADDR_W];
                    state_d = ST_ISSUE;
                end else if (ref_ack) begin
                    mode_d  = MODE_AUTOREF;
                    tgt_d   = ref_mask;
                    rep_d   = '0;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (gap_of(mode_q) != 0) begin
                    tmr_d   = TMR_W'(gap_of(mode_q) - 2);
                    state_d = ST_GAP;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_GAP: begin
                if (tmr_q != '0) begin
                    tmr_d = tmr_q - 1'b1;
                end else if (mode_q == MODE_AUTOREF && rep_q != '0) begin
                    rep_d   = rep_q - 1'b1;
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_NORMAL;
            tgt_q   <= '0;
            rep_q   <= '0;
            mrv_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            tgt_q   <= tgt_d;
            rep_q   <= rep_d;
            mrv_q   <= mrv_d;
            tmr_q   <= tmr_d;
        end
    end

    // Bus outputs
    always_comb begin
        cs_n  = '1;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        ba    = '0;
        if (state_q == ST_ISSUE) begin
            case (mode_q)
                MODE_PRECHARGE: begin
                    cs_n          = ~tgt_q;
                    ras_n         = 1'b0;
                    we_n          = 1'b0;
                    addr[A10_BIT] = 1'b1;
                end
                MODE_AUTOREF, MODE_SELF_REF: begin
                    cs_n  = ~tgt_q;
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                end
                MODE_LOAD_MR: begin
                    cs_n  = ~tgt_q;
                    ras_n = 1'b0;
                    cas_n = 1'b0;
                    we_n  = 1'b0;
                    addr  = mrv_q;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
    import sdram_cmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int T_RP   = 3,
    parameter int T_RC   = 7,
    parameter int T_MRD  = 2,
    parameter int IVAL_W = 13,
    localparam int CMD_W = MRV_LSB + ADDR_W,
    localparam int RT_W  = IVAL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              rfi_wr,
    input  logic [RT_W-1:0]   rfi_word,
    output logic              busy,
    output logic [NUM_CS-1:0] sd_cs_n,
    output logic [NUM_CS-1:0] sd_cke,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);

    logic              accept;
    op_mode_t          acc_mode;
    logic [NUM_CS-1:0] acc_tgt;
    logic [NUM_CS-1:0] ref_en;
    logic              ref_req;
    logic              ref_ack;
    logic              restart;

    assign restart = accept && (acc_mode == MODE_NORMAL) && (|acc_tgt);

    sdram_cmd_seq #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .T_RP   (T_RP),
        .T_RC   (T_RC),
        .T_MRD  (T_MRD)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .ref_req  (ref_req),
        .ref_mask (ref_en),
        .accept   (accept),
        .acc_mode (acc_mode),
        .acc_tgt  (acc_tgt),
        .ref_ack  (ref_ack),
        .busy     (busy),
        .cs_n     (sd_cs_n),
        .ras_n    (sd_ras_n),
        .cas_n    (sd_cas_n),
        .we_n     (sd_we_n),
        .addr     (sd_addr),
        .ba       (sd_ba)
    );

    sdram_bank_ctl u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .acc_mode (acc_mode),
        .acc_tgt  (acc_tgt),
        .cke      (sd_cke),
        .ref_en   (ref_en)
    );

    sdram_refresh_timer #(
        .RT_W (RT_W)
    ) u_rtimer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rt_wr   (rfi_wr),
        .rt_word (rfi_word),
        .restart (restart),
        .run     (|ref_en),
        .ack     (ref_ack),
        .req     (ref_req)
    );

endmodule

// File: rtl/sdram_cmd_engine_chk.sv
module sdram_cmd_engine_chk #(
    parameter int ADDR_W = 13,
    parameter int CMD_W  = 22,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic [CMD_W-1:0]  cmd_word,
    input logic              busy,
    input logic [1:0]        sd_cs_n,
    input logic [1:0]        sd_cke,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba
);

    logic any_cmd;
    assign any_cmd = (sd_cs_n != 2'b11);

    assert_idle_deselect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n));

    assert_cmd_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |=> !any_cmd);

    assert_pre_a10_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cmd && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[10]);

    assert_mrs_bank0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cmd && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_ba == '0));

    assert_reserved_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_word[2:0] == 3'd7) |=> !busy);

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_word[2:0] != 3'd7) |=> busy);

    assert_busy_cke_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sd_cke));

endmodule

bind sdram_cmd_engine sdram_cmd_engine_chk #(
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W),
    .BA_W   (BA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_word (cmd_word),
    .busy     (busy),
    .sd_cs_n  (sd_cs_n),
    .sd_cke   (sd_cke),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .sd_ba    (sd_ba)
);

// File: tb/tb_sdram_cmd_engine.sv
`timescale 1ns/1ps
module tb_sdram_cmd_engine;

    localparam int T_RP  = 3;
    localparam int T_RC  = 7;
    localparam int T_MRD = 2;
    localparam int IVAL  = 20;

    localparam logic [4:0] DESEL = 5'b11_111;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_REF = 3'b001;
    localparam logic [2:0] C_MRS = 3'b000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [21:0] cmd_word = '0;
    logic        rfi_wr = 1'b0;
    logic [13:0] rfi_word = '0;
    logic        busy;
    logic [1:0]  sd_cs_n;
    logic [1:0]  sd_cke;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    sdram_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .rfi_wr(rfi_wr), .rfi_word(rfi_word), .busy(busy),
        .sd_cs_n(sd_cs_n), .sd_cke(sd_cke), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    wire [4:0] bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    function automatic logic [21:0] mk(input logic [2:0] m, input logic b1, input logic b2,
                                       input logic [3:0] n, input logic [12:0] mr);
        return {mr, n, b1, b2, m};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Returns at the falling edge of the first cycle after the accepting edge.
    task automatic send(input logic [21:0] w);
        wait_idle();
        cmd_wr   = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_wr   = 1'b0;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(sd_cke == 2'b00, "R1 cke", sd_cke, 0);
        chk(bus == DESEL, "R1 bus", bus, DESEL);
    endtask

    task automatic t_reserved();
        send(mk(3'd7, 1, 1, 4'd0, 13'd0));
        chk(busy == 1'b0, "R2 mode7 busy", busy, 0);
        chk(bus == DESEL, "R2 mode7 bus", bus, DESEL);
        chk(sd_cke == 2'b00, "R2 mode7 cke", sd_cke, 0);
    endtask

    task automatic t_cke_on();
        send(mk(3'd1, 1, 0, 4'd0, 13'd0));
        chk(sd_cke == 2'b01, "R4 R5 cke bank1", sd_cke, 2'b01);
        chk(bus == DESEL, "R5 no command", bus, DESEL);
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R5 busy one cycle", busy, 0);
        send(mk(3'd1, 0, 1, 4'd0, 13'd0));
        chk(sd_cke == 2'b11, "R4 R5 cke bank2", sd_cke, 2'b11);
    endtask

    task automatic t_precharge();
        send(mk(3'd2, 1, 1, 4'd0, 13'd0));
        chk(bus == {2'b00, C_PRE}, "R6 precharge code", bus, {2'b00, C_PRE});
        chk(sd_addr[10] == 1'b1, "R6 A10", sd_addr[10], 1);
        for (int k = 1; k < T_RP; k++) begin
            @(negedge clk);
            chk(busy && bus == DESEL, "R6 R12 gap", {busy, bus}, {1'b1, DESEL});
        end
        @(negedge clk);
        chk(busy == 1'b0, "R6 busy end", busy, 0);
    endtask

    task automatic t_ignore_busy();
        send(mk(3'd2, 1, 0, 4'd0, 13'd0));
        chk(sd_cs_n == 2'b10, "R4 precharge bank1 only", sd_cs_n, 2'b10);
        cmd_wr   = 1'b1;
        cmd_word = mk(3'd6, 1, 1, 4'd0, 13'd0);
        @(negedge clk);
        cmd_wr   = 1'b0;
        wait_idle();
        chk(sd_cke == 2'b11, "R3 cke kept", sd_cke, 2'b11);
        @(negedge clk);
        chk(busy == 1'b0 && bus == DESEL, "R3 no late command", {busy, bus}, {1'b0, DESEL});
    endtask

    task automatic t_autoref(input logic b1, input logic b2, input int reps);
        int refs = 0;
        int bad = 0;
        logic [1:0] cs_exp;
        cs_exp = ~{b2, b1};
        send(mk(3'd3, b1, b2, 4'(reps - 1), 13'd0));
        for (int k = 0; k < reps * T_RC; k++) begin
            if (k % T_RC == 0) begin
                if (bus == {cs_exp, C_REF}) refs++; else bad++;
            end else if (bus != DESEL) bad++;
            if (!busy) bad++;
            @(negedge clk);
        end
        chk(refs == reps, "R7 refresh count", refs, reps);
        chk(bad == 0, "R7 R12 spacing", bad, 0);
        chk(busy == 1'b0, "R7 busy end", busy, 0);
    endtask

    task automatic t_load_mr();
        logic [12:0] mr = 13'h032;
        send(mk(3'd4, 1, 1, 4'd0, mr));
        chk(bus == {2'b00, C_MRS}, "R8 mrs code", bus, {2'b00, C_MRS});
        chk(sd_addr == mr, "R8 mrs address", sd_addr, mr);
        chk(sd_ba == 2'b00, "R8 bank address", sd_ba, 0);
        for (int k = 1; k < T_MRD; k++) @(negedge clk);
        chk(busy == 1'b1, "R8 busy last", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy end", busy, 0);
    endtask

    task automatic t_periodic();
        int first = -1;
        int second = -1;
        logic [1:0] cs1 = 2'b11;
        rfi_wr   = 1'b1;
        rfi_word = 14'(IVAL << 1);
        @(negedge clk);
        rfi_wr   = 1'b0;
        send(mk(3'd0, 1, 1, 4'd0, 13'd0));
        chk(bus == DESEL, "R9 normal no command", bus, DESEL);
        for (int k = 0; k <= 2 * IVAL + 4; k++) begin
            if (bus[2:0] == C_REF && bus[4:3] != 2'b11) begin
                if (first < 0) begin
                    first = k;
                    cs1 = sd_cs_n;
                end else if (second < 0) second = k;
            end
            @(negedge clk);
        end
        chk(first == IVAL + 2, "R10 first refresh", first, IVAL + 2);
        chk(second - first == IVAL + 1, "R10 refresh period", second - first, IVAL + 1);
        chk(cs1 == 2'b00, "R10 both banks", cs1, 0);
    endtask

    task automatic t_low_power();
        int seen = -1;
        int extra = 0;
        send(mk(3'd6, 0, 1, 4'd0, 13'd0));
        chk(sd_cke == 2'b01, "R11 power-down cke", sd_cke, 2'b01);
        chk(bus == DESEL, "R11 power-down no command", bus, DESEL);
        for (int k = 0; k < 2 * (IVAL + 2) + T_RC && seen < 0; k++) begin
            @(negedge clk);
            if (bus[2:0] == C_REF && bus[4:3] != 2'b11) seen = int'(sd_cs_n);
        end
        chk(seen == 2, "R11 refresh only bank1", seen, 2);
        send(mk(3'd5, 1, 0, 4'd0, 13'd0));
        chk(bus == {2'b10, C_REF}, "R11 self-refresh code", bus, {2'b10, C_REF});
        chk(sd_cke == 2'b00, "R11 self-refresh cke", sd_cke, 0);
        for (int k = 0; k < 3 * IVAL; k++) begin
            @(negedge clk);
            if (bus != DESEL) extra++;
        end
        chk(extra == 0, "R11 refresh stopped", extra, 0);
        send(mk(3'd0, 1, 0, 4'd0, 13'd0));
        chk(sd_cke == 2'b01, "R9 normal raises cke", sd_cke, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_cke_on();
        t_precharge();
        t_ignore_busy();
        t_autoref(1, 1, 8);
        t_autoref(0, 1, 3);
        t_load_mr();
        t_periodic();
        t_low_power();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule